// File: doc/BRIEF.md
# Asynchronous Bus Slave Register Front End

This block sits between an asynchronous microprocessor bus and a small bank of peripheral registers. The bus master selects the block with an active-low select line, gives the direction on a read/write level, places a register number on a short address field and, on writes, a byte on the input data lines. The block answers with an active-low transfer acknowledge. On a read it drives the acknowledge only once the register value is already on its data output. On a write it drives the acknowledge only once the byte is already held in the addressed register.

The block runs on its own clock. That clock may be faster or slower than the master's clock and has no fixed phase to it. For this reason the select and direction lines each pass through a two-stage synchroniser before any decision is made. Address and write data are taken straight from the bus, because the bus keeps them steady while the select is held low.

The register bank has NREG-1 byte-wide read/write registers, and all of them are presented to the peripheral logic on a flat output vector. The last address holds a status byte. Its bit 0 is a sticky event flag, set by a pulse on `evt_i`, which is synchronous to the block clock. The flag clears when the status byte is read.

Top module: `abus_slave`

## Requirements
- R1: With `rw` high, a selected cycle returns the addressed register on `data_o` (addresses 0..NREG-2 give the stored byte; address NREG-1 gives the status byte, flag in bit 0 and zeros above). With `rw` low, the cycle writes `data_i` into the addressed register.
- R2: A cycle starts only while the synchronised select is low. While `cs_n` is high, activity on `rw`, `addr` and `data_i` changes no register and leaves `dtack_n` high.
- R3: On a read, `data_oe` is high and `data_o` is valid three clocks after `cs_n` falls, which is one clock before `dtack_n` falls. `dtack_n` falls four clocks after `cs_n` falls.
- R4: On a write, the addressed register already holds the new byte one clock before `dtack_n` falls, which happens four clocks after `cs_n` falls. No other register changes.
- R5: `dtack_n` stays low until the synchronised select is seen high. It returns high, together with `data_oe` low, three clocks after `cs_n` rises.
- R6: Only one register write happens per cycle. Changing `data_i` while the select stays low after the acknowledge has no effect. A new cycle needs the select to be seen high first.
- R7: While `rst_n` is low, every read/write register is cleared, `dtack_n` is high, `data_oe` is low and `data_o` is zero. `data_o` is also zero whenever `data_oe` is low.
- R8: The status flag is zero after reset. A high `evt_i` sets it. Reading the status address clears it, but if an event arrives in the same cycle as the clearing read, the flag stays set. Writes to the status address are ignored.
- R9: Reading a read/write register leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, unrelated to the master clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low select, already qualified by the bus strobes |
| rw | input | 1 | High for read, low for write |
| addr | input | ADDR_W | Register number |
| data_i | input | DATA_W | Write data from the master |
| data_o | output | DATA_W | Read data toward the bus |
| data_oe | output | 1 | High while the block drives read data |
| dtack_n | output | 1 | Active-low transfer acknowledge |
| evt_i | input | 1 | Event pulse that sets the status flag |
| regs_o | output | (NREG-1)*DATA_W | Read/write registers, register i in bits i*DATA_W upward |

## Verification
Two functions can meet in one clock: the clear that a status read causes, and a new event that sets the same flag. The bench provokes this by holding `evt_i` high across a whole status read. It then reads the status byte again with no event present. That second read must return 1, which shows the set won over the clear, and a third read must return 0. A second overlap exists between a completed write and changing write data while the select stays low. It is judged by checking that the register keeps the first byte.

// File: rtl/abus_pkg.sv
package abus_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_DRIVE = 2'd1,
        BUS_HOLD  = 2'd2
    } bus_phase_e;

endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;

endmodule

// File: rtl/abus_cycle_ctrl.sv
module abus_cycle_ctrl
    import abus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              rw_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic              rd_en,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    output logic              dtack_n
);

    typedef struct packed {
        bus_phase_e        phase;
        logic [DATA_W-1:0] dout;
        logic              oe;
        logic              ack_n;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        rd_en = 1'b0;
        case (st_q.phase)
            BUS_IDLE: begin
                if (!cs_s) begin
                    st_d.phase = BUS_DRIVE;
                    if (rw_s) begin
                        rd_en     = 1'b1;
                        st_d.dout = rd_data;
                        st_d.oe   = 1'b1;
                    end else begin
                        wr_en = 1'b1;
                    end
                end
            end
            BUS_DRIVE: begin
                st_d.phase = BUS_HOLD;
                st_d.ack_n = 1'b0;
            end
            BUS_HOLD: begin
                if (cs_s) begin
                    st_d.phase = BUS_IDLE;
                    st_d.ack_n = 1'b1;
                    st_d.oe    = 1'b0;
                    st_d.dout  = '0;
                end
            end
            default: begin
                st_d.phase = BUS_IDLE;
                st_d.ack_n = 1'b1;
                st_d.oe    = 1'b0;
                st_d.dout  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= BUS_IDLE;
            st_q.dout  <= '0;
            st_q.oe    <= 1'b0;
            st_q.ack_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.dout;
    assign data_oe = st_q.oe;
    assign dtack_n = st_q.ack_n;

endmodule

// File: rtl/abus_reg_bank.sv
module abus_reg_bank #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int NREG   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic                         evt_i,
    output logic [DATA_W-1:0]            rd_data,
    output logic [(NREG-1)*DATA_W-1:0]   regs_o
);

    localparam int NRW       = NREG - 1;
    localparam int STAT_ADDR = NREG - 1;

    typedef struct packed {
        logic [NRW-1:0][DATA_W-1:0] regs;
        logic                       flag;
    } bank_t;

    bank_t st_d, st_q;
    logic  stat_hit;

    assign stat_hit = (addr == ADDR_W'(STAT_ADDR));

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NRW; i++) begin
            if (wr_en && addr == ADDR_W'(i)) begin
                st_d.regs[i] = wr_data;
            end
        end
        st_d.flag = evt_i | (st_q.flag & ~(rd_en & stat_hit));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NRW; i++) begin
            if (addr == ADDR_W'(i)) begin
                rd_data = st_q.regs[i];
            end
        end
        if (stat_hit) begin
            rd_data = DATA_W'(st_q.flag);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NRW; g++) begin : g_flat
        assign regs_o[g*DATA_W +: DATA_W] = st_q.regs[g];
    end

endmodule

// File: rtl/abus_slave.sv
module abus_slave #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int NREG   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       rw,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          data_i,
    output logic [DATA_W-1:0]          data_o,
    output logic                       data_oe,
    output logic                       dtack_n,
    input  logic                       evt_i,
    output logic [(NREG-1)*DATA_W-1:0] regs_o
);

    logic              cs_s;
    logic              rw_s;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] rd_data;

    abus_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, rw}),
        .q     ({cs_s, rw_s})
    );

    abus_cycle_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .rw_s    (rw_s),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .data_o  (data_o),
        .data_oe (data_oe),
        .dtack_n (dtack_n)
    );

    abus_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_data (data_i),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .evt_i   (evt_i),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

endmodule

// File: rtl/abus_slave_chk.sv
module abus_slave_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              dtack_n,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_o,
    input logic              wr_en,
    input logic              rd_en
);

    // R3
    ack_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> ($stable(data_oe) && $stable(data_o)));

    // R5
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !cs_s) |=> !dtack_n);

    // R6
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R2
    start_on_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |-> (!cs_s && dtack_n));

    // R7
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_o == '0));

endmodule

bind abus_slave abus_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .dtack_n (dtack_n),
    .data_oe (data_oe),
    .data_o  (data_o),
    .wr_en   (wr_en),
    .rd_en   (rd_en)
);

// File: tb/abus_slave_bench.sv
module abus_slave_bench;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int NREG   = 8;
    localparam int NRW    = NREG - 1;
    localparam int STAT   = NREG - 1;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   cs_n;
    logic                   rw;
    logic [ADDR_W-1:0]      addr;
    logic [DATA_W-1:0]      data_i;
    logic [DATA_W-1:0]      data_o;
    logic                   data_oe;
    logic                   dtack_n;
    logic                   evt_i;
    logic [NRW*DATA_W-1:0]  regs_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [DATA_W-1:0] model [NRW];

    always #4 clk = ~clk;

    abus_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) u_abus_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .rw      (rw),
        .addr    (addr),
        .data_i  (data_i),
        .data_o  (data_o),
        .data_oe (data_oe),
        .dtack_n (dtack_n),
        .evt_i   (evt_i),
        .regs_o  (regs_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_regs();
        logic [63:0] v = '0;
        for (int i = 0; i < NRW; i++) v[i*DATA_W +: DATA_W] = model[i];
        return v;
    endfunction

    task automatic release_bus();
        cs_n = 1'b1;
        tick(); tick();
        chk("R5 ack held until select seen high", dtack_n, 1'b0);
        tick();
        chk("R5 ack released three clocks after select rises", dtack_n, 1'b1);
        chk("R5 output enable dropped with ack", data_oe, 1'b0);
        chk("R7 data zero when not enabled", data_o, '0);
    endtask

    task automatic bus_write(input int a, input logic [DATA_W-1:0] d, input bit hold);
        addr = ADDR_W'(a); data_i = d; rw = 1'b0; cs_n = 1'b0;
        if (a < NRW) model[a] = d;
        tick(); tick(); tick();
        chk("R4 register holds byte before ack", regs_o, exp_regs());
        chk("R4 ack still high at capture", dtack_n, 1'b1);
        chk("R1 no drive on write", data_oe, 1'b0);
        tick();
        chk("R4 ack falls four clocks after select", dtack_n, 1'b0);
        if (hold) begin
            data_i = ~d;
            repeat (3) tick();
            chk("R6 late data not written", regs_o, exp_regs());
            chk("R6 ack kept during hold", dtack_n, 1'b0);
        end
        release_bus();
    endtask

    task automatic bus_read(input int a, input logic [DATA_W-1:0] exp);
        addr = ADDR_W'(a); rw = 1'b1; cs_n = 1'b0;
        tick(); tick(); tick();
        chk("R3 data enabled before ack", data_oe, 1'b1);
        chk("R1 read data", data_o, exp);
        chk("R3 ack still high while data driven", dtack_n, 1'b1);
        tick();
        chk("R3 ack falls four clocks after select", dtack_n, 1'b0);
        chk("R3 data valid during ack", data_o, exp);
        release_bus();
    endtask

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; rw = 1'b1; addr = '0; data_i = '0; evt_i = 1'b0;
        for (int i = 0; i < NRW; i++) model[i] = '0;
        repeat (3) tick();
        chk("R7 ack high in reset", dtack_n, 1'b1);
        chk("R7 enable low in reset", data_oe, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R7 registers cleared", regs_o, '0);
        chk("R7 data zero after reset", data_o, '0);

        // R2: bus activity without select
        for (int i = 0; i < 6; i++) begin
            rw = 1'b0; addr = ADDR_W'(i); data_i = DATA_W'(8'hA5 + i);
            tick();
            chk("R2 no write without select", regs_o, exp_regs());
            chk("R2 no ack without select", dtack_n, 1'b1);
        end

        // R1 R4 R6 R9 sweep
        for (int p = 0; p < 3; p++) begin
            for (int a = 0; a < NRW; a++) begin
                bus_write(a, DATA_W'(p * 91 + a * 29 + 3), a == p);
            end
            for (int a = 0; a < NRW; a++) begin
                bus_read(a, model[a]);
            end
            chk("R9 reads leave registers unchanged", regs_o, exp_regs());
        end
        bus_write(2, 8'hFF, 1'b0);
        bus_write(5, 8'h00, 1'b1);
        bus_read(2, 8'hFF);
        bus_read(5, 8'h00);

        // R8 status flag
        bus_read(STAT, 8'h00);
        evt_i = 1'b1; tick(); evt_i = 1'b0;
        bus_read(STAT, 8'h01);
        bus_read(STAT, 8'h00);
        bus_write(STAT, 8'hFF, 1'b0);
        chk("R8 status write ignored by registers", regs_o, exp_regs());
        bus_read(STAT, 8'h00);
        evt_i = 1'b1; tick();
        bus_read(STAT, 8'h01);
        evt_i = 1'b0;
        bus_read(STAT, 8'h01);  // R8 set won over clearing read
        bus_read(STAT, 8'h00);

        // R7 reset after use
        rst_n = 1'b0;
        tick();
        chk("R7 registers cleared by reset", regs_o, '0);
        rst_n = 1'b1;
        for (int i = 0; i < NRW; i++) model[i] = '0;
        tick();
        bus_read(3, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule